// File: doc/BRIEF.md
# Banked Interrupt Aggregator

This block collects a parameterised number of interrupt request lines, organised in groups of 32 called banks, and folds them into a single registered interrupt towards a host processor. Each line can be captured either as a level, where the latched status follows the line one cycle late, or as a rising edge, where a sticky status bit holds the event until software clears it. Per-line enables select which latched events count as pending.

Software talks to the block through a single-cycle register port: an address, a write strobe, write data, and combinational read data. Enables are never written directly. One register sets enable bits and another clears them, so concurrent software agents cannot undo each other's changes. Two independent gates sit in front of the output. A global enable switches the whole aggregation on or off. An output gate lets an interrupt handler silence the pin in its fast first stage and reopen it after deferred processing, while status keeps updating underneath.

The output stage is a three-state machine. GATE_OFF holds while the global enable is 0. GATE_ARMED means the block is enabled but nothing is signalled. GATE_FIRING drives the pin. The transitions are named as follows. Switch-on moves from GATE_OFF to GATE_ARMED. Fire moves from GATE_OFF or GATE_ARMED to GATE_FIRING when something is pending and the output gate is open. Quiesce moves from GATE_FIRING to GATE_ARMED when the pending condition or the output gate drops. Switch-off moves from any state back to GATE_OFF when the global enable is cleared. The machine is evaluated every cycle, so the pin is a registered copy of the global enable AND the output gate AND the pending OR.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Address 0x00 is read-only and returns the line count in bits 15:0 and the VERSION parameter in bits 31:16. Writes to it have no effect.
- R2: In bank b, the enable-set register sits at word address 0x10+8*b+0. Writing a 1 bit there sets that line's enable, and 0 bits leave the enables unchanged. Reads of offset +0 and offset +1 both return the current enables.
- R3: Writing a 1 bit to the enable-clear register at bank offset +1 clears that line's enable. 0 bits leave the enables unchanged.
- R4: A line whose type bit is 0 is level-captured. Its latched status, readable at bank offset +2, equals the line's value at the previous clock edge.
- R5: The type register at bank offset +3 is read/write, and a type bit of 1 selects rising-edge capture. A rising edge of the line sets the latched status bit. The bit stays set until a 1 is written to bank offset +2. If a rising edge and that clear happen in the same cycle, the bit ends up set.
- R6: The masked status at bank offset +4 is read-only and equals the latched status AND the enables.
- R7: Bit 0 of address 0x01 is the read/write global enable. Address 0x03 is read-only, and its bit 0 is the global enable AND the OR of all masked status bits.
- R8: Bit 0 of address 0x02 is the read/write output gate. The pin irq_out is 1 in the cycle after one in which global enable, output gate and any masked status bit are all 1, and is 0 otherwise. Latched status and address 0x03 keep updating while the gate is 0.
- R9: After reset all enables, type bits, latched status, the global enable and the output gate read 0, and irq_out is 0.
- R10: Addresses that are not mapped read as 0. Writes to them, to address 0x00, to address 0x03 or to masked status registers change no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Interrupt request lines, synchronous to clk |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Registered interrupt to the host |

## Verification
The bench builds the block with NUM_LINES set to 96 and VERSION set to 0x0203. This gives three banks, so bank decode is exercised past the second bank, the last bank's top bit is reachable, and bank-sized addresses beyond the third bank fall into the unmapped range. With an 8-bit address, the identification, control, per-bank and unmapped decode regions can all be swept by a random phase. A behavioural model tracks the register state and the one-cycle pin latency on every clock. Directed steps cover gate toggling around a pending line, sticky edge capture, and a clear that coincides with a rising edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LINES_PER_BANK = 32;

    // word addresses of the global registers
    localparam int ID_ADDR    = 0;
    localparam int MEN_ADDR   = 1;
    localparam int OEN_ADDR   = 2;
    localparam int MSTAT_ADDR = 3;

    // per-bank windows start here, 8 words each
    localparam int BANK_BASE     = 16;
    localparam int BANK_SPAN_LOG = 3;

    typedef enum logic [2:0] {
        RG_EN_SET  = 3'd0,
        RG_EN_CLR  = 3'd1,
        RG_RAW_CLR = 3'd2,
        RG_TYPE    = 3'd3,
        RG_MASKED  = 3'd4
    } bank_reg_e;

    typedef enum logic [1:0] {
        GATE_OFF    = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_FIRING = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic raw_clr;
        logic typ_wr;
    } bank_wr_t;

endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int WIDTH = LINES_PER_BANK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lines_i,
    input  bank_wr_t         wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  bank_reg_e        rsel_i,
    output logic [WIDTH-1:0] en_o,
    output logic [WIDTH-1:0] typ_o,
    output logic [WIDTH-1:0] raw_o,
    output logic [31:0]      rdata_o
);

    logic [WIDTH-1:0] en_q, typ_q, raw_q, prev_q;
    logic [WIDTH-1:0] raw_d, clr_mask;

    assign clr_mask = wr_i.raw_clr ? wdata_i : '0;

    // one capture cell per line: edge mode is sticky with set priority
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic rise;
        assign rise     = lines_i[i] & ~prev_q[i];
        assign raw_d[i] = typ_q[i] ? ((raw_q[i] & ~clr_mask[i]) | rise)
                                   : lines_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            typ_q  <= '0;
            raw_q  <= '0;
            prev_q <= '0;
        end else begin
            raw_q  <= raw_d;
            prev_q <= lines_i;
            if (wr_i.en_set)
                en_q <= en_q | wdata_i;
            else if (wr_i.en_clr)
                en_q <= en_q & ~wdata_i;
            if (wr_i.typ_wr)
                typ_q <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (rsel_i)
            RG_EN_SET,
            RG_EN_CLR:  rdata_o[WIDTH-1:0] = en_q;
            RG_RAW_CLR: rdata_o[WIDTH-1:0] = raw_q;
            RG_TYPE:    rdata_o[WIDTH-1:0] = typ_q;
            RG_MASKED:  rdata_o[WIDTH-1:0] = raw_q & en_q;
            default:    rdata_o = '0;
        endcase
    end

    assign en_o  = en_q;
    assign typ_o = typ_q;
    assign raw_o = raw_q;

endmodule

// File: rtl/irqc_out_fsm.sv
module irqc_out_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_en_i,
    input  logic out_en_i,
    input  logic pending_i,
    output logic irq_o
);

    gate_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= GATE_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: begin
                if (master_en_i && out_en_i && pending_i)
                    state_d = GATE_FIRING;      // fire
                else if (master_en_i)
                    state_d = GATE_ARMED;       // switch-on
            end
            GATE_ARMED: begin
                if (!master_en_i)
                    state_d = GATE_OFF;         // switch-off
                else if (out_en_i && pending_i)
                    state_d = GATE_FIRING;      // fire
            end
            GATE_FIRING: begin
                if (!master_en_i)
                    state_d = GATE_OFF;         // switch-off
                else if (!(out_en_i && pending_i))
                    state_d = GATE_ARMED;       // quiesce
            end
            default: state_d = GATE_OFF;
        endcase
    end

    always_comb begin
        irq_o = (state_q == GATE_FIRING);
    end

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int          NUM_LINES = 64,
    parameter logic [15:0] VERSION   = 16'h0102,
    parameter int          ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 irq_out
);

    localparam int NB     = NUM_LINES / LINES_PER_BANK;
    localparam int BIDX_W = ADDR_W - BANK_SPAN_LOG;

    logic [ADDR_W-1:0] boff;
    logic [BIDX_W-1:0] bidx;
    logic              in_bank;
    bank_reg_e         rsel;

    logic master_en, out_en, pending, mstat;

    logic [NUM_LINES-1:0] en_all, typ_all, raw_all;
    logic [31:0]          bank_rd [NB];
    bank_wr_t             bank_wr [NB];

    assign boff    = bus_addr - ADDR_W'(BANK_BASE);
    assign bidx    = boff[ADDR_W-1:BANK_SPAN_LOG];
    assign rsel    = bank_reg_e'(boff[BANK_SPAN_LOG-1:0]);
    assign in_bank = (bus_addr >= ADDR_W'(BANK_BASE)) && (int'(bidx) < NB);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit;
        assign hit = bus_we && in_bank && (bidx == BIDX_W'(b));

        assign bank_wr[b].en_set  = hit && (rsel == RG_EN_SET);
        assign bank_wr[b].en_clr  = hit && (rsel == RG_EN_CLR);
        assign bank_wr[b].raw_clr = hit && (rsel == RG_RAW_CLR);
        assign bank_wr[b].typ_wr  = hit && (rsel == RG_TYPE);

        irqc_bank #(.WIDTH(LINES_PER_BANK)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .lines_i (irq_lines[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .wr_i    (bank_wr[b]),
            .wdata_i (bus_wdata),
            .rsel_i  (rsel),
            .en_o    (en_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .typ_o   (typ_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .raw_o   (raw_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .rdata_o (bank_rd[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_en <= 1'b0;
            out_en    <= 1'b0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(MEN_ADDR))
                master_en <= bus_wdata[0];
            if (bus_addr == ADDR_W'(OEN_ADDR))
                out_en <= bus_wdata[0];
        end
    end

    assign pending = |(raw_all & en_all);
    assign mstat   = master_en & pending;

    irqc_out_fsm gate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_en_i (master_en),
        .out_en_i    (out_en),
        .pending_i   (pending),
        .irq_o       (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ID_ADDR))
            bus_rdata = {VERSION, 16'(NUM_LINES)};
        else if (bus_addr == ADDR_W'(MEN_ADDR))
            bus_rdata = {31'd0, master_en};
        else if (bus_addr == ADDR_W'(OEN_ADDR))
            bus_rdata = {31'd0, out_en};
        else if (bus_addr == ADDR_W'(MSTAT_ADDR))
            bus_rdata = {31'd0, mstat};
        else if (in_bank) begin
            for (int b = 0; b < NB; b++)
                if (bidx == BIDX_W'(b))
                    bus_rdata = bank_rd[b];
        end
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int          NUM_LINES = 64,
    parameter logic [15:0] VERSION   = 16'h0102,
    parameter int          ADDR_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              wdata0,
    input logic [31:0]       bus_rdata,
    input logic              irq_out,
    input logic              master_en,
    input logic              out_en,
    input logic              pending,
    input logic              line0,
    input logic              en0,
    input logic              typ0,
    input logic              raw0
);

    assert_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ID_ADDR)) |-> (bus_rdata == {VERSION, 16'(NUM_LINES)}));

    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(BANK_BASE) && wdata0) |=> en0);

    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(BANK_BASE + 1) && wdata0) |=> !en0);

    assert_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !typ0 |=> (raw0 == $past(line0)));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (typ0 && raw0) |=>
            (raw0 || $past(bus_we && bus_addr == ADDR_W'(BANK_BASE + 2) && wdata0)));

    assert_mstat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(MSTAT_ADDR) && !master_en) |-> (bus_rdata == 32'd0));

    assert_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(master_en && out_en && pending));

endmodule

bind banked_irq_ctrl irqc_checker #(
    .NUM_LINES (NUM_LINES),
    .VERSION   (VERSION),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .wdata0    (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .master_en (master_en),
    .out_en    (out_en),
    .pending   (pending),
    .line0     (irq_lines[0]),
    .en0       (en_all[0]),
    .typ0      (typ_all[0]),
    .raw0      (raw_all[0])
);

// File: tb/banked_irq_ctrl_tb_top.sv
module banked_irq_ctrl_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          LINES      = 96;
    localparam int          NBK        = LINES / 32;
    localparam logic [15:0] VER        = 16'h0203;
    localparam logic [31:0] ID_VAL     = {16'h0203, 16'd96};

    logic             clk = 1'b0;
    logic             rst_n;
    logic [LINES-1:0] irq_lines;
    logic [7:0]       bus_addr;
    logic             bus_we;
    logic [31:0]      bus_wdata;
    logic [31:0]      bus_rdata;
    logic             irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // behavioural reference state
    bit [31:0] m_en   [NBK];
    bit [31:0] m_typ  [NBK];
    bit [31:0] m_raw  [NBK];
    bit [31:0] m_prev [NBK];
    bit        m_me, m_oe, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_irq_ctrl #(.NUM_LINES(LINES), .VERSION(VER), .ADDR_W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    function automatic bit [31:0] mread(input logic [7:0] a);
        int ai = int'(a);
        if (ai == 0) return ID_VAL;
        if (ai == 1) return {31'd0, m_me};
        if (ai == 2) return {31'd0, m_oe};
        if (ai == 3) begin
            bit any = 0;
            for (int b = 0; b < NBK; b++) any |= |(m_raw[b] & m_en[b]);
            return {31'd0, m_me & any};
        end
        if (ai >= 16 && (ai - 16) / 8 < NBK) begin
            int b = (ai - 16) / 8;
            case ((ai - 16) % 8)
                0, 1:    return m_en[b];
                2:       return m_raw[b];
                3:       return m_typ[b];
                4:       return m_raw[b] & m_en[b];
                default: return 32'd0;
            endcase
        end
        return 32'd0;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        int ai = int'(a);
        if (ai == 0) return "R1";
        if (ai == 1 || ai == 3) return "R7";
        if (ai == 2) return "R8";
        if (ai >= 16 && (ai - 16) / 8 < NBK) begin
            case ((ai - 16) % 8)
                0:       return "R2";
                1:       return "R3";
                2:       return "R4";
                3:       return "R5";
                4:       return "R6";
                default: return "R10";
            endcase
        end
        return "R10";
    endfunction

    // advance the model over one clock edge using the inputs held across it
    task automatic model_edge();
        bit any = 0;
        int ai = int'(bus_addr);
        for (int b = 0; b < NBK; b++) any |= |(m_raw[b] & m_en[b]);
        for (int b = 0; b < NBK; b++) begin
            bit [31:0] ln  = irq_lines[b*32 +: 32];
            bit [31:0] clr = (bus_we && ai == 16 + 8*b + 2) ? bus_wdata : 32'd0;
            bit [31:0] nr;
            for (int i = 0; i < 32; i++)
                nr[i] = m_typ[b][i] ? ((m_raw[b][i] & ~clr[i]) | (ln[i] & ~m_prev[b][i]))
                                    : ln[i];
            m_raw[b]  = nr;
            m_prev[b] = ln;
        end
        m_irq = m_me & m_oe & any;
        if (bus_we) begin
            if (ai == 1) m_me = bus_wdata[0];
            if (ai == 2) m_oe = bus_wdata[0];
            if (ai >= 16 && (ai - 16) / 8 < NBK) begin
                int b = (ai - 16) / 8;
                case ((ai - 16) % 8)
                    0: m_en[b]  = m_en[b] | bus_wdata;
                    1: m_en[b]  = m_en[b] & ~bus_wdata;
                    3: m_typ[b] = bus_wdata;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        bus_we = 1'b0;
        chk("R8 irq_out vs model", {31'd0, irq_out}, {31'd0, m_irq});
        chk({tag_of(bus_addr), " read vs model"}, bus_rdata, mread(bus_addr));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        step();
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        irq_lines = '0;
        bus_addr  = '0;
        bus_we    = 1'b0;
        bus_wdata = '0;
        rst_n     = 1'b0;
        m_me = 0; m_oe = 0; m_irq = 0;
        for (int b = 0; b < NBK; b++) begin
            m_en[b] = 0; m_typ[b] = 0; m_raw[b] = 0; m_prev[b] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state, R1 identification
        chk("R9 irq_out after reset", {31'd0, irq_out}, 32'd0);
        rd(8'd0, ID_VAL, "R1 id register");
        rd(8'd1, 32'd0, "R9 master enable");
        rd(8'd2, 32'd0, "R9 output gate");
        rd(8'd3, 32'd0, "R9 master status");
        for (int a = 16; a < 16 + 8*NBK; a++) rd(8'(a), 32'd0, "R9 bank register");

        // R2 / R3 enables
        wr(8'd16, 32'h0000_00FF);
        rd(8'd16, 32'h0000_00FF, "R2 set");
        rd(8'd17, 32'h0000_00FF, "R2 readback at clear offset");
        wr(8'd16, 32'h0000_0100);
        rd(8'd16, 32'h0000_01FF, "R2 zero bits keep enables");
        wr(8'd17, 32'h0000_000F);
        rd(8'd16, 32'h0000_01F0, "R3 clear");
        wr(8'd32, 32'h8000_0000);
        rd(8'd32, 32'h8000_0000, "R2 third bank top bit");

        // R4 level capture, R6 masking, R7 global enable
        irq_lines[4] = 1'b1;
        step();
        rd(8'd18, 32'h0000_0010, "R4 level latched");
        rd(8'd20, 32'h0000_0010, "R6 masked");
        irq_lines[0] = 1'b1;
        step();
        rd(8'd18, 32'h0000_0011, "R4 second line");
        rd(8'd20, 32'h0000_0010, "R6 disabled line masked");
        rd(8'd3, 32'd0, "R7 status with global enable off");
        chk("R7 pin with global enable off", {31'd0, irq_out}, 32'd0);

        wr(8'd1, 32'd1);
        rd(8'd3, 32'd1, "R7 status");
        step();
        chk("R8 gate closed", {31'd0, irq_out}, 32'd0);

        // R8 output gate and its latency
        wr(8'd2, 32'd1);
        chk("R8 pin one cycle late", {31'd0, irq_out}, 32'd0);
        step();
        chk("R8 pin asserted", {31'd0, irq_out}, 32'd1);
        wr(8'd2, 32'd0);
        chk("R8 pin drops one cycle late", {31'd0, irq_out}, 32'd1);
        step();
        chk("R8 pin masked", {31'd0, irq_out}, 32'd0);
        rd(8'd3, 32'd1, "R8 status updates while masked");

        irq_lines[4] = 1'b0;
        step();
        rd(8'd18, 32'h0000_0001, "R4 follows low");
        irq_lines[0] = 1'b0;
        step();
        rd(8'd18, 32'h0000_0000, "R4 all low");

        // R5 edge capture in bank 1, line 3
        wr(8'd27, 32'h0000_0008);
        rd(8'd27, 32'h0000_0008, "R5 type readback");
        wr(8'd24, 32'h0000_0008);
        irq_lines[35] = 1'b1;
        step();
        rd(8'd26, 32'h0000_0008, "R5 rising edge captured");
        irq_lines[35] = 1'b0;
        step();
        step();
        rd(8'd26, 32'h0000_0008, "R5 sticky after line falls");
        rd(8'd28, 32'h0000_0008, "R6 edge masked");
        wr(8'd26, 32'h0000_0008);
        rd(8'd26, 32'h0000_0000, "R5 cleared");
        irq_lines[35] = 1'b1;
        wr(8'd26, 32'h0000_0008);
        rd(8'd26, 32'h0000_0008, "R5 set wins over clear");
        step();
        rd(8'd26, 32'h0000_0008, "R5 high line no new edge");
        irq_lines[35] = 1'b0;

        // R10 unmapped and read-only
        rd(8'd8, 32'd0, "R10 hole");
        rd(8'hF0, 32'd0, "R10 past last bank");
        rd(8'd21, 32'd0, "R10 unused bank offset");
        wr(8'd0, 32'hFFFF_FFFF);
        rd(8'd0, ID_VAL, "R10 id write ignored");
        wr(8'd20, 32'hFFFF_FFFF);
        rd(8'd16, 32'h0000_01F0, "R10 masked write leaves enables");
        wr(8'd8, 32'hFFFF_FFFF);
        rd(8'd1, 32'd1, "R10 hole write leaves global enable");

        // random phase, model compared every cycle
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 3) == 0)
                irq_lines = {$urandom, $urandom, $urandom};
            bus_addr  = 8'($urandom_range(0, 47));
            bus_wdata = $urandom;
            bus_we    = ($urandom_range(0, 9) < 3);
            step();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule